// File: doc/BRIEF.md
# CPU-to-PCI Window Decoder

This block checks each CPU physical address against two decode windows and reports a hit flag and a window-relative offset for each one. The first window is a programmable PCI I/O aperture. Its position and size come from a low/high pair of decode registers. The second is a fixed 4 KB window that maps the host bridge's own registers. A small register bus writes the decode registers and reads them back. Both windows are computed combinationally from the registered values, so a write changes the decode on the cycle right after the write edge.

Each window is first derived from its registers. It is then trimmed so that it never overlaps two fixed reserved holes in the address map. These holes are `[0x1E000000, 0x1F100000)` and `[0x1FC00000, 0x1FD00000)`. A window that becomes empty after trimming never hits. A companion remap value is captured along with the I/O low register. It is stored and can be read back, but the decoder does not use it for translation. When an address falls in both windows, the register window wins.

Top module: `cpu_pci_win_dec`

## Requirements
- R1: After reset the registers read back as follows: selector 0 (I/O low) = 0x80, selector 1 (I/O high) = 0x0F, selector 2 (remap) = 0x80, selector 3 (register-window base) = 0xA0. This places the I/O window at 0x10000000 with a size of 32 MB, and the register window at 0x14000000.
- R2: A write to selector 0 stores data bits [14:0] as the I/O low register. The same write stores data bits [10:0] into the remap register.
- R3: A write to selector 1 keeps bits [6:0] only. A write to selector 2 keeps bits [10:0]. A write to selector 3 keeps bits [14:0]. Unused read bits return zero.
- R4: The I/O window is enabled only when I/O low bits [6:0] are less than or equal to I/O high. While it is disabled, `io_hit` stays low.
- R5: The I/O window base is the full 15-bit low register shifted left by 21. Its length is (high + 1 - low[6:0]) shifted left by 21. `io_hit` is high when base <= address < base + length, and `io_off` = address - base.
- R6: The register window base is the selector 3 register shifted left by 21, and the window is 0x1000 bytes long. `reg_off` = address - base, and `reg_off` is always below 0x1000 when `reg_hit` is high.
- R7: Clipping, applied to both windows in this order:
  - An end that lies in hole A is moved to the start of hole A.
  - A start that lies in hole A is moved to the end of hole A.
  - The same two rules are then applied for hole B.
  - A window that starts below a hole and ends at or above that hole's end has its start moved to that hole's end.
- R8: A window whose length is zero after clipping never asserts its hit flag.
- R9: When an address lies in both windows, `reg_hit` is high, and `io_hit` is low with `io_off` = 0.
- R10: `io_off` is zero whenever `io_hit` is low, and `reg_off` is zero whenever `reg_hit` is low.
- R11: The register contents change only on a clock edge where `wr_en` is high. The decode outputs reflect a write from the first cycle after its edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write register selector (0 low, 1 high, 2 remap, 3 register-window base) |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read register selector, same coding as `wr_sel` |
| rd_data | output | 32 | Zero-extended contents of the selected register |
| cpu_addr | input | 32 | CPU physical address to decode |
| io_hit | output | 1 | Address lies in the PCI I/O window |
| io_off | output | 32 | Offset into the I/O window |
| reg_hit | output | 1 | Address lies in the register window |
| reg_off | output | 12 | Offset into the register window |

## Verification
Two things can coincide in one cycle: the I/O window hit and the register window hit. The bench provokes this in two ways. Directed writes move the I/O aperture over the register window. Random writes also land the low register near the register-window base. Each probe is judged against a bench-side model that computes both windows independently and applies the priority: the register hit must be reported, and the I/O outputs must be forced to zero. The same model covers the coincidence of a register write with a decode change. The probe taken one cycle after a write must already see the new window.

// File: rtl/win_dec_pkg.sv
package win_dec_pkg;

  // Register selector coding shared by the write and read ports.
  typedef enum logic [1:0] {
    SEL_IO_LO   = 2'd0,
    SEL_IO_HI   = 2'd1,
    SEL_REMAP   = 2'd2,
    SEL_RW_BASE = 2'd3
  } reg_sel_e;

  // Window index inside the generate loop; lower index has priority.
  localparam int unsigned WIN_REGS = 0;
  localparam int unsigned WIN_IO   = 1;
  localparam int unsigned NUM_WIN  = 2;

endpackage

// File: rtl/wdec_rst_sync.sv
module wdec_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/wdec_regs.sv
module wdec_regs
  import win_dec_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned LO_W     = 15,
  parameter int unsigned HI_W     = 7,
  parameter int unsigned REMAP_W  = 11,
  parameter logic [LO_W-1:0]    LO_RST    = 15'h0080,
  parameter logic [HI_W-1:0]    HI_RST    = 7'h0F,
  parameter logic [REMAP_W-1:0] REMAP_RST = 11'h080,
  parameter logic [LO_W-1:0]    RW_RST    = 15'h00A0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [1:0]         rd_sel,
  output logic [DATA_W-1:0]  rd_data,
  output logic [LO_W-1:0]    lo_q,
  output logic [HI_W-1:0]    hi_q,
  output logic [REMAP_W-1:0] remap_q,
  output logic [LO_W-1:0]    rw_q
);

  logic [LO_W-1:0]    lo_d;
  logic [HI_W-1:0]    hi_d;
  logic [REMAP_W-1:0] remap_d;
  logic [LO_W-1:0]    rw_d;
  logic               lo_en, hi_en, remap_en, rw_en;

  // Next-state and clock enables
  always_comb begin
    lo_en    = wr_en && (reg_sel_e'(wr_sel) == SEL_IO_LO);
    hi_en    = wr_en && (reg_sel_e'(wr_sel) == SEL_IO_HI);
    // the low-register write also refreshes the remap copy
    remap_en = wr_en && ((reg_sel_e'(wr_sel) == SEL_REMAP) ||
                         (reg_sel_e'(wr_sel) == SEL_IO_LO));
    rw_en    = wr_en && (reg_sel_e'(wr_sel) == SEL_RW_BASE);
    lo_d     = wr_data[LO_W-1:0];
    hi_d     = wr_data[HI_W-1:0];
    remap_d  = wr_data[REMAP_W-1:0];
    rw_d     = wr_data[LO_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= LO_RST;
      hi_q    <= HI_RST;
      remap_q <= REMAP_RST;
      rw_q    <= RW_RST;
    end else begin
      if (lo_en)    lo_q    <= lo_d;
      if (hi_en)    hi_q    <= hi_d;
      if (remap_en) remap_q <= remap_d;
      if (rw_en)    rw_q    <= rw_d;
    end
  end

  always_comb begin
    unique case (reg_sel_e'(rd_sel))
      SEL_IO_LO:   rd_data = DATA_W'(lo_q);
      SEL_IO_HI:   rd_data = DATA_W'(hi_q);
      SEL_REMAP:   rd_data = DATA_W'(remap_q);
      SEL_RW_BASE: rd_data = DATA_W'(rw_q);
      default:     rd_data = '0;
    endcase
  end

endmodule

// File: rtl/wdec_span.sv
module wdec_span #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned LO_W      = 15,
  parameter int unsigned HI_W      = 7,
  parameter int unsigned SHIFT     = 21,
  parameter bit          FIXED     = 1'b0,
  parameter int unsigned FIXED_LEN = 4096,
  parameter logic [ADDR_W-1:0] HA_LO = 32'h1E00_0000,
  parameter logic [ADDR_W-1:0] HA_HI = 32'h1F10_0000,
  parameter logic [ADDR_W-1:0] HB_LO = 32'h1FC0_0000,
  parameter logic [ADDR_W-1:0] HB_HI = 32'h1FD0_0000,
  localparam int unsigned EW = LO_W + SHIFT + 1
) (
  input  logic [LO_W-1:0] lo,
  input  logic [HI_W-1:0] hi,
  output logic [EW-1:0]   cbase,
  output logic [EW-1:0]   clen
);

  localparam logic [EW-1:0] A_LO = EW'(HA_LO);
  localparam logic [EW-1:0] A_HI = EW'(HA_HI);
  localparam logic [EW-1:0] B_LO = EW'(HB_LO);
  localparam logic [EW-1:0] B_HI = EW'(HB_HI);

  logic [EW-1:0] raw_base;
  logic [EW-1:0] raw_len;
  logic [EW-1:0] b, e;

  assign raw_base = EW'(lo) << SHIFT;

  generate
    if (FIXED) begin : g_fixed
      assign raw_len = EW'(FIXED_LEN);
    end else begin : g_ranged
      logic [HI_W:0] units;
      logic          enable;
      always_comb begin
        enable = (lo[HI_W-1:0] <= hi);
        units  = {1'b0, hi} + (HI_W+1)'(1) - {1'b0, lo[HI_W-1:0]};
      end
      assign raw_len = enable ? (EW'(units) << SHIFT) : '0;
    end
  endgenerate

  // Trim around the reserved holes, order matters
  always_comb begin
    b = raw_base;
    e = raw_base + raw_len;
    if (e >= A_LO && e < A_HI) e = A_LO;
    if (b >= A_LO && b < A_HI) b = A_HI;
    if (e >= B_LO && e < B_HI) e = B_LO;
    if (b >= B_LO && b < B_HI) b = B_HI;
    if (e >= A_HI && b < A_LO) b = A_HI;
    if (e >= B_HI && b < B_LO) b = B_HI;
    cbase = b;
    clen  = (e > b) ? (e - b) : '0;
  end

endmodule

// File: rtl/wdec_match.sv
module wdec_match #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned EW     = 37
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [EW-1:0]     cbase,
  input  logic [EW-1:0]     clen,
  output logic              hit,
  output logic [ADDR_W-1:0] off
);

  logic [EW-1:0] addr_x;
  logic [EW-1:0] diff;

  always_comb begin
    addr_x = EW'(addr);
    diff   = addr_x - cbase;
    hit    = (clen != '0) && (addr_x >= cbase) && (diff < clen);
    off    = diff[ADDR_W-1:0];
  end

endmodule

// File: rtl/cpu_pci_win_dec.sv
module cpu_pci_win_dec
  import win_dec_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned LO_W       = 15,
  parameter int unsigned HI_W       = 7,
  parameter int unsigned REMAP_W    = 11,
  parameter int unsigned SHIFT      = 21,
  parameter int unsigned RW_BYTES   = 4096,
  parameter logic [ADDR_W-1:0] HA_LO = 32'h1E00_0000,
  parameter logic [ADDR_W-1:0] HA_HI = 32'h1F10_0000,
  parameter logic [ADDR_W-1:0] HB_LO = 32'h1FC0_0000,
  parameter logic [ADDR_W-1:0] HB_HI = 32'h1FD0_0000,
  localparam int unsigned RW_OFF_W  = $clog2(RW_BYTES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [1:0]          rd_sel,
  output logic [DATA_W-1:0]   rd_data,
  input  logic [ADDR_W-1:0]   cpu_addr,
  output logic                io_hit,
  output logic [ADDR_W-1:0]   io_off,
  output logic                reg_hit,
  output logic [RW_OFF_W-1:0] reg_off
);

  localparam int unsigned EW = LO_W + SHIFT + 1;

  logic               rst_q_n;
  logic [LO_W-1:0]    lo_q;
  logic [HI_W-1:0]    hi_q;
  logic [REMAP_W-1:0] remap_q;
  logic [LO_W-1:0]    rw_q;

  logic [NUM_WIN-1:0] hit_w;
  logic [ADDR_W-1:0]  off_w [NUM_WIN];

  wdec_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  wdec_regs #(
    .DATA_W  (DATA_W),
    .LO_W    (LO_W),
    .HI_W    (HI_W),
    .REMAP_W (REMAP_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .rd_sel  (rd_sel),
    .rd_data (rd_data),
    .lo_q    (lo_q),
    .hi_q    (hi_q),
    .remap_q (remap_q),
    .rw_q    (rw_q)
  );

  generate
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      localparam bit IS_FIXED = (w == WIN_REGS);
      logic [EW-1:0] cbase, clen;

      wdec_span #(
        .ADDR_W    (ADDR_W),
        .LO_W      (LO_W),
        .HI_W      (HI_W),
        .SHIFT     (SHIFT),
        .FIXED     (IS_FIXED),
        .FIXED_LEN (RW_BYTES),
        .HA_LO     (HA_LO),
        .HA_HI     (HA_HI),
        .HB_LO     (HB_LO),
        .HB_HI     (HB_HI)
      ) u_span (
        .lo    (IS_FIXED ? rw_q : lo_q),
        .hi    (IS_FIXED ? '0 : hi_q),
        .cbase (cbase),
        .clen  (clen)
      );

      wdec_match #(
        .ADDR_W (ADDR_W),
        .EW     (EW)
      ) u_match (
        .addr  (cpu_addr),
        .cbase (cbase),
        .clen  (clen),
        .hit   (hit_w[w]),
        .off   (off_w[w])
      );
    end
  endgenerate

  // Register window has priority; offsets gated by the final hit flags
  always_comb begin
    reg_hit = hit_w[WIN_REGS];
    io_hit  = hit_w[WIN_IO] && !hit_w[WIN_REGS];
    reg_off = reg_hit ? off_w[WIN_REGS][RW_OFF_W-1:0] : '0;
    io_off  = io_hit  ? off_w[WIN_IO] : '0;
  end

endmodule

// File: rtl/wdec_checker.sv
module wdec_checker #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned LO_W     = 15,
  parameter int unsigned HI_W     = 7,
  parameter int unsigned REMAP_W  = 11,
  parameter int unsigned RW_OFF_W = 12
) (
  input logic                clk,
  input logic                rst_q_n,
  input logic                wr_en,
  input logic [1:0]          wr_sel,
  input logic [DATA_W-1:0]   wr_data,
  input logic [LO_W-1:0]     lo_q,
  input logic [HI_W-1:0]     hi_q,
  input logic [REMAP_W-1:0]  remap_q,
  input logic [LO_W-1:0]     rw_q,
  input logic                io_hit,
  input logic [ADDR_W-1:0]   io_off,
  input logic                reg_hit,
  input logic [RW_OFF_W-1:0] reg_off
);

  // R2
  lo_remap_copy_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_en && wr_sel == 2'd0) |=>
      (lo_q == $past(wr_data[LO_W-1:0]) && remap_q == $past(wr_data[REMAP_W-1:0])));

  // R3
  hi_mask_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_en && wr_sel == 2'd1) |=> (hi_q == $past(wr_data[HI_W-1:0])));

  // R4
  io_disabled_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (lo_q[HI_W-1:0] > hi_q) |-> !io_hit);

  // R9
  one_window_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(io_hit && reg_hit));

  // R10
  io_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !io_hit |-> (io_off == '0));

  // R10
  reg_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !reg_hit |-> (reg_off == '0));

  // R11
  hold_regs_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !wr_en |=> ($stable(lo_q) && $stable(hi_q) && $stable(remap_q) && $stable(rw_q)));

endmodule

bind cpu_pci_win_dec wdec_checker #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .LO_W     (LO_W),
  .HI_W     (HI_W),
  .REMAP_W  (REMAP_W),
  .RW_OFF_W (RW_OFF_W)
) chk_i (
  .clk     (clk),
  .rst_q_n (rst_q_n),
  .wr_en   (wr_en),
  .wr_sel  (wr_sel),
  .wr_data (wr_data),
  .lo_q    (lo_q),
  .hi_q    (hi_q),
  .remap_q (remap_q),
  .rw_q    (rw_q),
  .io_hit  (io_hit),
  .io_off  (io_off),
  .reg_hit (reg_hit),
  .reg_off (reg_off)
);

// File: tb/cpu_pci_win_dec_tb_top.sv
module cpu_pci_win_dec_tb_top;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic [1:0]  rd_sel;
  logic [31:0] rd_data;
  logic [31:0] cpu_addr;
  logic        io_hit;
  logic [31:0] io_off;
  logic        reg_hit;
  logic [11:0] reg_off;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // bench-side copy of the register state, updated from the requirements
  logic [14:0] m_lo, m_rw;
  logic [6:0]  m_hi;
  logic [10:0] m_remap;

  cpu_pci_win_dec dut_i (
    .clk (clk), .rst_n (rst_n),
    .wr_en (wr_en), .wr_sel (wr_sel), .wr_data (wr_data),
    .rd_sel (rd_sel), .rd_data (rd_data),
    .cpu_addr (cpu_addr),
    .io_hit (io_hit), .io_off (io_off),
    .reg_hit (reg_hit), .reg_off (reg_off)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag,
                       input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // reserved-hole trimming (R7) and zero-length handling (R8)
  task automatic clip(input logic [39:0] rb, input logic [39:0] rl,
                      output logic [39:0] cb, output logic [39:0] cl);
    logic [39:0] b, e;
    b = rb; e = rb + rl;
    if (e >= 40'h1E00_0000 && e < 40'h1F10_0000) e = 40'h1E00_0000;
    if (b >= 40'h1E00_0000 && b < 40'h1F10_0000) b = 40'h1F10_0000;
    if (e >= 40'h1FC0_0000 && e < 40'h1FD0_0000) e = 40'h1FC0_0000;
    if (b >= 40'h1FC0_0000 && b < 40'h1FD0_0000) b = 40'h1FD0_0000;
    if (e >= 40'h1F10_0000 && b < 40'h1E00_0000) b = 40'h1F10_0000;
    if (e >= 40'h1FD0_0000 && b < 40'h1FC0_0000) b = 40'h1FD0_0000;
    cb = b;
    cl = (e > b) ? e - b : 40'd0;
  endtask

  task automatic expect_dec(input logic [31:0] a,
                            output bit eio, output logic [31:0] eio_off,
                            output bit erg, output logic [11:0] erg_off);
    logic [39:0] rb, rl, cb, cl, ax;
    ax = {8'd0, a};
    // R5: full low register for the base, low 7 bits for the length
    rb = {25'd0, m_lo} << 21;
    rl = (m_lo[6:0] <= m_hi) ? ((40'(m_hi) + 40'd1 - 40'(m_lo[6:0])) << 21) : 40'd0;
    clip(rb, rl, cb, cl);
    eio = (cl != 0) && (ax >= cb) && (ax - cb < cl);
    eio_off = eio ? 32'(ax - cb) : 32'd0;
    // R6: fixed 4 KB register window
    clip({25'd0, m_rw} << 21, 40'h1000, cb, cl);
    erg = (cl != 0) && (ax >= cb) && (ax - cb < cl);
    erg_off = erg ? 12'(ax - cb) : 12'd0;
    // R9: register window takes priority
    if (erg) begin eio = 1'b0; eio_off = 32'd0; end
  endtask

  task automatic probe(input logic [31:0] a, input string tag);
    bit eio, erg;
    logic [31:0] eo;
    logic [11:0] er;
    @(negedge clk);
    cpu_addr = a;
    #1;
    expect_dec(a, eio, eo, erg, er);
    check(io_hit == eio,  {tag, " io_hit"},  40'(io_hit),  40'(eio));
    check(io_off == eo,   {tag, " io_off"},  40'(io_off),  40'(eo));
    check(reg_hit == erg, {tag, " reg_hit"}, 40'(reg_hit), 40'(erg));
    check(reg_off == er,  {tag, " reg_off"}, 40'(reg_off), 40'(er));
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (sel)
      2'd0: begin m_lo = d[14:0]; m_remap = d[10:0]; end
      2'd1: m_hi = d[6:0];
      2'd2: m_remap = d[10:0];
      default: m_rw = d[14:0];
    endcase
  endtask

  task automatic rd_check(input logic [1:0] sel, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_sel = sel;
    #1;
    check(rd_data == exp, tag, 40'(rd_data), 40'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0;
    rd_sel = 2'd0; cpu_addr = '0;
    m_lo = 15'h80; m_hi = 7'h0F; m_remap = 11'h080; m_rw = 15'hA0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_check(2'd0, 32'h80, "R1 lo reset");
    rd_check(2'd1, 32'h0F, "R1 hi reset");
    rd_check(2'd2, 32'h80, "R1 remap reset");
    rd_check(2'd3, 32'hA0, "R1 rw reset");
    probe(32'h1000_0000, "R1 io base");
    probe(32'h11FF_FFFF, "R5 io last byte");
    probe(32'h1200_0000, "R5 io past end");
    probe(32'h1400_0000, "R6 reg base");
    probe(32'h1400_0FFF, "R6 reg last");
    probe(32'h1400_1000, "R6 reg past end");

    // R2 / R3 masking and remap copy
    wr(2'd0, 32'hFFFF_FF80);
    rd_check(2'd0, 32'h7F80, "R2 lo mask");
    rd_check(2'd2, 32'h780,  "R2 remap copy");
    wr(2'd1, 32'hFFFF_FFF3);
    rd_check(2'd1, 32'h73, "R3 hi mask");
    wr(2'd2, 32'hFFFF_F123);
    rd_check(2'd2, 32'h123, "R3 remap mask");
    rd_check(2'd0, 32'h7F80, "R3 remap write leaves lo");

    // R5 full base register, R11 decode follows write at once
    wr(2'd1, 32'h0F);
    wr(2'd0, 32'h180);
    probe(32'h3000_0004, "R11 R5 upper base");
    probe(32'h1000_0000, "R5 old base gone");

    // R4 disabled window
    wr(2'd0, 32'h85);
    wr(2'd1, 32'h03);
    probe(32'h10A0_0000, "R4 disabled");

    // R9 overlap with register window
    wr(2'd0, 32'hA0);
    wr(2'd1, 32'h2F);
    probe(32'h1400_0010, "R9 overlap");
    probe(32'h1400_1000, "R9 io beyond reg");

    // R7 end clipped into hole A
    wr(2'd0, 32'hE8);
    wr(2'd1, 32'h77);
    probe(32'h1DFF_FFFF, "R7 end clip in");
    probe(32'h1E00_0000, "R7 end clip out");
    // R8 window fully inside hole A
    wr(2'd0, 32'hF0);
    probe(32'h1E00_0000, "R8 empty window");
    probe(32'h1F10_0000, "R8 empty window after");
    // R7 start in hole B
    wr(2'd0, 32'hFE);
    wr(2'd1, 32'h7F);
    probe(32'h1FCF_FFFF, "R7 start clip out");
    probe(32'h1FD0_0000, "R7 start clip in");
    // R7 spanning both holes
    wr(2'd0, 32'hE8);
    probe(32'h1D00_0000, "R7 span low gone");
    probe(32'h1FD0_0000, "R7 span new base");
    // R7 register window in a hole
    wr(2'd3, 32'hF0);
    probe(32'h1E00_0000, "R7 reg window clipped");
    wr(2'd3, 32'hA0);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int unsigned r;
      logic [31:0] a, base;
      r = $urandom % 10;
      if (r < 3) begin
        logic [1:0] s;
        s = 2'($urandom % 4);
        wr(s, ($urandom % 4 == 0) ? $urandom : ($urandom & 32'h0000_07FF));
      end
      base = (($urandom % 2) == 0) ? ({17'd0, m_lo} << 21) : ({17'd0, m_rw} << 21);
      case ($urandom % 4)
        0: a = $urandom;
        1: a = base + ($urandom % 32'h0000_2000) - 32'h1000;
        2: a = base + ({11'd0, $urandom % 32'd256} << 17);
        default: a = 32'h1DF0_0000 + ($urandom % 32'h0200_0000);
      endcase
      probe(a, "R5 R6 R9 R10 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule